// File: doc/BRIEF.md
# Asynchronous Serial Word Receiver

This block accepts a three-wire serial stream: a source clock, a data bit and an active-high frame qualifier. The source clock may run anywhere from a few kHz up to 10 MHz and has no phase relationship to the local system clock. The receiver brings only the source clock into the system domain, through a chain of metastability flops. It then detects the rising edge of the synchronized copy. Data and qualifier change on that same source edge. The synchronizer delay outlasts their skew, so both are sampled directly, without synchronizers, at the moment the edge is seen.

Each accepted bit is shifted into a word register, most significant bit first. When the sixteenth bit of a frame arrives, the finished word is presented on a parallel output together with a strobe that lasts one system clock. If the qualifier drops part way through a frame, the bits gathered so far are thrown away, and the next frame starts at bit position zero.

Top module: `serial_word_rx`

## Requirements
- R1: An active-low asynchronous reset drives `wordOut` to 0 and `wordValid` to 0 at once, and discards any partly received word; the first word after reset is assembled from its first bit.
- R2: The first bit accepted in a frame ends up in `wordOut[15]` and the sixteenth in `wordOut[0]`.
- R3: After the serial clock rise that carries bit 16, `wordValid` stays 0 through the second rising `clk` edge. It is 1 from the third rising `clk` edge until the fourth, and the completed word is on `wordOut` during that cycle.
- R4: Exactly one bit is taken per serial clock period, however many system clocks the serial clock stays high or low.
- R5: Serial clock rises that occur while `serEnv` is 0 take no bit and produce no strobe. The bit position is not advanced, so the next qualified frame assembles correctly.
- R6: When `serEnv` is 0 for a system clock, any partial word is discarded. A following frame is assembled from scratch, and the partial bits produce no strobe.
- R7: `wordOut` keeps the last completed word until the next word completes.
- R8: Frames sent back to back with `serEnv` held at 1 are each delivered, each with its own strobe.
- R9: A serial clock of 2 system clocks high and 2 low (a 4-clock bit time) is received correctly.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serClk | input | 1 | Serial source clock, asynchronous to clk |
| serData | input | 1 | Serial data, changes on the serClk rise |
| serEnv | input | 1 | Frame qualifier, active high, changes on the serClk rise |
| wordOut | output | 16 | Last completed word |
| wordValid | output | 1 | One-cycle strobe marking a new word |

## Verification
The bench targets cases where a slip in the bit counter or the edge logic would go unnoticed in ordinary traffic. In one case the qualifier drops after a few bits. A receiver that keeps its count would then fire early, with a word made of stale bits mixed with new ones. In another, the serial clock stays high for many system clocks. A design that samples on the level instead of the edge would fill the word with copies of one bit. Other runs cover frames sent back to back, qualifier-low clock activity, the fastest bit time and a reset in mid-frame. A counter that wraps wrongly, leaks bits while the qualifier is low, or is not cleared by reset would give a wrong word or a wrong number of strobes in these runs. The exact strobe cycle is also checked, to catch an extra or missing register stage.

// File: rtl/rx_pkg.sv
package rx_pkg;
  // strobes from the control path to the word datapath
  typedef struct packed {
    logic shiftEn;   // take one data bit this cycle
    logic lastBit;   // this bit completes the word
  } rxStrobe_t;
endpackage

// File: rtl/rx_sync.sv
module rx_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic din,
  output logic dout
);
  logic [STAGES-1:0] pipe;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) pipe <= '0;
    else       pipe <= {pipe[STAGES-2:0], din};
  end

  // single fanout point for the synchronized level
  assign dout = pipe[STAGES-1];
endmodule

// File: rtl/rx_ctrl.sv
module rx_ctrl
  import rx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             serClk,
  input  logic             serEnv,
  output rxStrobe_t        stb,
  output logic             envQ,
  output logic [CNT_W-1:0] bitCnt
);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(WORD_W - 1);

  logic syncClk;
  logic prevClk;
  logic riseSeen;

  rx_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk (clk),
    .rstN(rstN),
    .din (serClk),
    .dout(syncClk)
  );

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      prevClk <= 1'b0;
      envQ    <= 1'b0;
    end else begin
      prevClk <= syncClk;
      envQ    <= serEnv;   // single flop, settled before the edge is seen
    end
  end

  assign riseSeen    = syncClk & ~prevClk;
  assign stb.shiftEn = riseSeen & envQ;
  assign stb.lastBit = stb.shiftEn && (bitCnt == LAST_IDX);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)              bitCnt <= '0;
    else if (!envQ)         bitCnt <= '0;
    else if (stb.lastBit)   bitCnt <= '0;
    else if (stb.shiftEn)   bitCnt <= bitCnt + 1'b1;
  end
endmodule

// File: rtl/rx_datapath.sv
module rx_datapath
  import rx_pkg::*;
#(
  parameter int WORD_W = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serData,
  input  rxStrobe_t         stb,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  logic [WORD_W-2:0] shiftReg;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shiftReg  <= '0;
      wordOut   <= '0;
      wordValid <= 1'b0;
    end else begin
      wordValid <= stb.lastBit;
      if (stb.shiftEn) shiftReg <= {shiftReg[WORD_W-3:0], serData};
      if (stb.lastBit) wordOut  <= {shiftReg, serData};
    end
  end
endmodule

// File: rtl/serial_word_rx.sv
module serial_word_rx
  import rx_pkg::*;
#(
  parameter int WORD_W      = 16,
  parameter int SYNC_STAGES = 2,
  localparam int CNT_W      = $clog2(WORD_W)
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serClk,
  input  logic              serData,
  input  logic              serEnv,
  output logic [WORD_W-1:0] wordOut,
  output logic              wordValid
);
  rxStrobe_t        stb;
  logic             envQ;
  logic [CNT_W-1:0] bitCnt;

  rx_ctrl #(.WORD_W(WORD_W), .SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk   (clk),
    .rstN  (rstN),
    .serClk(serClk),
    .serEnv(serEnv),
    .stb   (stb),
    .envQ  (envQ),
    .bitCnt(bitCnt)
  );

  rx_datapath #(.WORD_W(WORD_W)) u_dp (
    .clk      (clk),
    .rstN     (rstN),
    .serData  (serData),
    .stb      (stb),
    .wordOut  (wordOut),
    .wordValid(wordValid)
  );
endmodule

// File: rtl/rx_checker.sv
module rx_checker #(
  parameter int WORD_W = 16,
  parameter int CNT_W  = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              serEnv,
  input logic              shiftEn,
  input logic              lastBit,
  input logic              envQ,
  input logic [CNT_W-1:0]  bitCnt,
  input logic [WORD_W-1:0] wordOut,
  input logic              wordValid
);
  p_strobe_single_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |=> !wordValid);

  p_strobe_follows_last_r3: assert property (@(posedge clk) disable iff (!rstN)
    lastBit |=> wordValid);

  p_strobe_has_cause_r3: assert property (@(posedge clk) disable iff (!rstN)
    wordValid |-> $past(lastBit));

  p_one_bit_per_rise_r4: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |=> !shiftEn);

  p_env_gates_capture_r5: assert property (@(posedge clk) disable iff (!rstN)
    shiftEn |-> $past(serEnv));

  p_env_drop_clears_r6: assert property (@(posedge clk) disable iff (!rstN)
    !envQ |=> (bitCnt == '0));

  p_word_held_r7: assert property (@(posedge clk) disable iff (!rstN)
    !wordValid |-> $stable(wordOut));
endmodule

bind serial_word_rx rx_checker #(.WORD_W(WORD_W), .CNT_W(CNT_W)) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .serEnv   (serEnv),
  .shiftEn  (stb.shiftEn),
  .lastBit  (stb.lastBit),
  .envQ     (envQ),
  .bitCnt   (bitCnt),
  .wordOut  (wordOut),
  .wordValid(wordValid)
);

// File: tb/sim_serial_word_rx.sv
module sim_serial_word_rx;
  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        serClk = 1'b0;
  logic        serData = 1'b0;
  logic        serEnv = 1'b0;
  logic [15:0] wordOut;
  logic        wordValid;

  int total = 0;
  int bad = 0;
  int pulseCnt = 0;
  int dblCnt = 0;
  logic [15:0] gotWord = '0;
  logic [15:0] seen [0:63];
  logic prevV = 1'b0;
  int cycles = 0;

  localparam int NVEC = 6;
  localparam logic [15:0] VEC [0:NVEC-1] = '{16'hA5C3, 16'h0001, 16'h8000,
                                             16'hFFFF, 16'h0000, 16'h1234};

  serial_word_rx u0 (
    .clk(clk), .rstN(rstN), .serClk(serClk), .serData(serData),
    .serEnv(serEnv), .wordOut(wordOut), .wordValid(wordValid)
  );

  always #10 clk = ~clk;

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog act=%0d exp<150000", cycles);
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  // output monitor, sampled away from the active edge
  always @(negedge clk) begin
    if (!rstN) prevV = 1'b0;
    else begin
      if (wordValid) begin
        if (prevV) dblCnt++;
        seen[pulseCnt % 64] = wordOut;
        pulseCnt++;
        gotWord = wordOut;
      end
      prevV = wordValid;
    end
  end

  task automatic chk(input bit ok, input string req, input logic [31:0] act,
                     input logic [31:0] exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s act=%0h exp=%0h", req, act, exp);
    end
  endtask

  // called at a negedge; one serial clock period
  task automatic sendBit(input logic b, input logic env, input int hi, input int lo);
    serData = b; serEnv = env; serClk = 1'b1;
    repeat (hi) @(negedge clk);
    serClk = 1'b0;
    repeat (lo) @(negedge clk);
  endtask

  task automatic sendWord(input logic [15:0] w, input int hi, input int lo);
    for (int i = 15; i >= 0; i--) sendBit(w[i], 1'b1, hi, lo);
    repeat (2) @(negedge clk);
  endtask

  initial begin
    int p0;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(wordOut == 16'h0, "R1 reset word", wordOut, 0);
    chk(wordValid == 1'b0, "R1 reset strobe", wordValid, 0);
    rstN = 1'b1;
    repeat (3) @(negedge clk);

    // table of words, R2 bit order and R8 continuous envelope
    for (int k = 0; k < NVEC; k++) begin
      p0 = pulseCnt;
      sendWord(VEC[k], 4, 4);
      chk(pulseCnt == p0 + 1, "R8 one strobe per word", pulseCnt - p0, 1);
      chk(gotWord == VEC[k], "R2 word order", gotWord, VEC[k]);
    end
    chk(dblCnt == 0, "R3 strobe width", dblCnt, 0);

    // R3 exact strobe cycle
    w = 16'h6C39;
    for (int i = 15; i >= 1; i--) sendBit(w[i], 1'b1, 8, 8);
    serData = w[0]; serClk = 1'b1;
    repeat (2) @(negedge clk);
    chk(wordValid == 1'b0, "R3 not before third edge", wordValid, 0);
    @(negedge clk);
    chk(wordValid == 1'b1, "R3 strobe at third edge", wordValid, 1);
    chk(wordOut == w, "R3 word with strobe", wordOut, w);
    @(negedge clk);
    chk(wordValid == 1'b0, "R3 strobe one cycle", wordValid, 0);
    repeat (4) @(negedge clk);
    serClk = 1'b0;
    repeat (8) @(negedge clk);

    // R4 slow serial clock, long high level
    p0 = pulseCnt;
    sendWord(16'h5AF0, 40, 40);
    chk(pulseCnt == p0 + 1 && gotWord == 16'h5AF0, "R4 slow clock word", gotWord, 16'h5AF0);

    // R9 fastest bit time
    p0 = pulseCnt;
    sendWord(16'h3E71, 2, 2);
    chk(pulseCnt == p0 + 1 && gotWord == 16'h3E71, "R9 fast clock word", gotWord, 16'h3E71);

    // R5 clocking with envelope low, R7 word held
    p0 = pulseCnt;
    for (int i = 0; i < 20; i++) sendBit(i[0], 1'b0, 3, 3);
    repeat (4) @(negedge clk);
    chk(pulseCnt == p0, "R5 no strobe with envelope low", pulseCnt - p0, 0);
    chk(wordOut == 16'h3E71, "R7 word held", wordOut, 16'h3E71);
    sendWord(16'h9B4D, 4, 4);
    chk(pulseCnt == p0 + 1 && gotWord == 16'h9B4D, "R5 next word aligned", gotWord, 16'h9B4D);

    // R6 partial frame discarded
    p0 = pulseCnt;
    for (int i = 0; i < 7; i++) sendBit(1'b1, 1'b1, 4, 4);
    serEnv = 1'b0;
    repeat (6) @(negedge clk);
    chk(pulseCnt == p0, "R6 no strobe for partial", pulseCnt - p0, 0);
    sendWord(16'h0F0F, 4, 4);
    chk(pulseCnt == p0 + 1, "R6 single strobe", pulseCnt - p0, 1);
    chk(gotWord == 16'h0F0F, "R6 fresh word", gotWord, 16'h0F0F);

    // R8 back to back, two words
    p0 = pulseCnt;
    sendWord(16'hBEEF, 3, 3);
    sendWord(16'h4271, 3, 3);
    chk(pulseCnt == p0 + 2, "R8 two strobes", pulseCnt - p0, 2);
    chk(seen[p0 % 64] == 16'hBEEF, "R8 first word", seen[p0 % 64], 16'hBEEF);
    chk(gotWord == 16'h4271, "R8 second word", gotWord, 16'h4271);

    // R1 reset in mid frame
    for (int i = 0; i < 9; i++) sendBit(1'b1, 1'b1, 4, 4);
    rstN = 1'b0;
    #1;
    chk(wordOut == 16'h0 && wordValid == 1'b0, "R1 async clear", wordOut, 0);
    repeat (2) @(negedge clk);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    p0 = pulseCnt;
    sendWord(16'h2DA6, 4, 4);
    chk(pulseCnt == p0 + 1 && gotWord == 16'h2DA6, "R1 first word after reset", gotWord, 16'h2DA6);
    chk(dblCnt == 0, "R3 no wide strobe overall", dblCnt, 0);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule